// File: doc/BRIEF.md
# Ping-Pong Hybrid Time-to-Digital Converter Channel

This block is one measurement lane of a time-to-digital converter that combines a coarse clock-cycle counter with a fine, sub-cycle interpolation taken from tapped delay lines. The lane owns two delay-line sample ports. It swaps their roles on every clock: one line launches the current input level while the other line, which launched during the previous cycle, is sampled and returned to rest. Because of this swap, a new interval can be captured in every cycle and the lane accepts events at the full clock rate. In this project the delay lines are modelled as sampled thermometer vectors on the ports. The encoder reduces a sample to its count of ones.

Each input pulse gives two fine values. The leading value is sampled in the cycle where the pulse is first seen high, and the trailing value in the cycle where it is first seen low again. The trailing edge closes a record. The record is the coarse cycle count since the previous record, scaled to tap units, plus both fine values. Records go into a result FIFO that a memory-mapped host drains. A full FIFO keeps its older data and lets the newest entry be replaced, and a sticky flag reports that this happened. The lane also keeps, for each line, the farthest tap ever reached, and the host can read it.

Top module: `hybrid_tdc_lane`

## Requirements
- R1: After reset the FIFO is empty (`resEmpty`=1, `resLevel`=0), `ovfSticky`=0, both reach outputs are 0 and `activeSel`=0.
- R2: `activeSel` inverts on every clock edge out of reset (0 means line A launches and line B is sampled; 1 means the reverse). `launchBit` is 1 while `pulseIn` is low and 0 while it is high.
- R3: At the edge where `pulseIn` is first seen high, the leading fine value is taken as the number of ones on the line that `activeSel` marks as sampled. At the edge where `pulseIn` is first seen low after being high, the trailing fine value is taken the same way.
- R4: At the trailing edge, exactly one record equal to coarse*TAPS + leading + trailing is written to the FIFO.
- R5: The coarse count is the number of clock edges after the previous record edge (or after reset release) and before the current record edge.
- R6: The coarse count saturates at 2^COARSE_W-1 and does not wrap.
- R7: The FIFO is first in, first out. `resRd` removes the head, and `resData` shows the head. `resRd` on an empty FIFO is ignored.
- R8: When a record arrives at a full FIFO with no read in that cycle, it replaces the newest entry. The level stays DEPTH and all older entries are kept.
- R9: `ovfSticky` is set by every overwrite and is cleared by `ovfClr`. If both happen in the same cycle, the set wins.
- R10: `reachA` and `reachB` each hold the largest count of ones ever sampled from their line.
- R11: `resLevel` equals the number of stored records and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Channel input pulse, at least one cycle high and one cycle low |
| lineA | input | TAPS | Sampled taps of delay line A |
| lineB | input | TAPS | Sampled taps of delay line B |
| launchBit | output | 1 | Level launched into the active line |
| activeSel | output | 1 | Active line select (0 = A, 1 = B) |
| resRd | input | 1 | Host read strobe, pops the FIFO head |
| resData | output | REC_W | FIFO head record |
| resEmpty | output | 1 | FIFO empty |
| resLevel | output | $clog2(DEPTH+1) | Number of stored records |
| ovfClr | input | 1 | Host write that clears the overflow flag |
| ovfSticky | output | 1 | Sticky overwrite indicator |
| reachA | output | $clog2(TAPS+1) | Farthest tap reached on line A |
| reachB | output | $clog2(TAPS+1) | Farthest tap reached on line B |

## Verification
The main function is tried with a set of pulses that vary the idle gap, the pulse width and the two fine values. Gaps of zero and of many cycles separate the coarse term from the fine terms. Fine values of 0 and full scale (all taps) check the encoder limits. Pulses wider than one cycle confirm that the leading value is taken only at the first high cycle. In a separate phase, different counts are placed on the two lines in known phases to show which line is sampled and that each reach register keeps its maximum. Further runs fill the FIFO beyond capacity, hold the input idle past the coarse limit, and read an empty FIFO.

// File: rtl/tdc_lane_pkg.sv
package tdc_lane_pkg;
  typedef struct packed {
    logic leadStb;
    logic recStb;
    logic phase;
  } laneStrobe_t;
endpackage

// File: rtl/tdc_lane_ctrl.sv
module tdc_lane_ctrl
  import tdc_lane_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pulseIn,
  output laneStrobe_t stb,
  output logic        launchBit
);
  logic pulseQ;
  logic phaseQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulseQ <= 1'b0;
      phaseQ <= 1'b0;
    end else begin
      pulseQ <= pulseIn;
      phaseQ <= ~phaseQ;
    end
  end

  always_comb begin
    stb.leadStb = pulseIn & ~pulseQ;
    stb.recStb  = ~pulseIn & pulseQ;
    stb.phase   = phaseQ;
    launchBit   = ~pulseIn;
  end
endmodule

// File: rtl/tdc_lane_dpath.sv
module tdc_lane_dpath
  import tdc_lane_pkg::*;
#(
  parameter int TAPS     = 64,
  parameter int COARSE_W = 24,
  parameter int REC_W    = 36,
  localparam int FINE_W  = $clog2(TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  laneStrobe_t       stb,
  input  logic [TAPS-1:0]   lineA,
  input  logic [TAPS-1:0]   lineB,
  output logic              recValid,
  output logic [REC_W-1:0]  recData,
  output logic [FINE_W-1:0] reachA,
  output logic [FINE_W-1:0] reachB
);
  localparam logic [COARSE_W-1:0] CMAX = '1;

  logic [TAPS-1:0]   lineSet [2];
  logic [FINE_W-1:0] reachQ  [2];
  logic              sampIdx;
  logic [FINE_W-1:0] fineNow;
  logic [FINE_W-1:0] leadHold;
  logic [COARSE_W-1:0] coarseCnt;

  function automatic logic [FINE_W-1:0] onesCount(input logic [TAPS-1:0] v);
    logic [FINE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < TAPS; i++) acc = acc + {{(FINE_W-1){1'b0}}, v[i]};
    return acc;
  endfunction

  assign lineSet[0] = lineA;
  assign lineSet[1] = lineB;
  // the line that launched in the previous cycle is the one sampled now
  assign sampIdx = ~stb.phase;
  assign fineNow = onesCount(lineSet[sampIdx]);

  for (genvar g = 0; g < 2; g++) begin : gReach
    always_ff @(posedge clk) begin
      if (!rst_n) reachQ[g] <= '0;
      else if ((sampIdx == 1'(g)) && (fineNow > reachQ[g])) reachQ[g] <= fineNow;
    end
  end
  assign reachA = reachQ[0];
  assign reachB = reachQ[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leadHold  <= '0;
      coarseCnt <= '0;
    end else begin
      if (stb.leadStb) leadHold <= fineNow;
      if (stb.recStb) coarseCnt <= '0;
      else if (coarseCnt != CMAX) coarseCnt <= coarseCnt + 1'b1;
    end
  end

  always_comb begin
    recValid = stb.recStb;
    recData  = REC_W'(coarseCnt) * REC_W'(TAPS) + REC_W'(leadHold) + REC_W'(fineNow);
  end
endmodule

// File: rtl/tdc_result_fifo.sv
module tdc_result_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 36,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     headData,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  input  logic             ovfClr,
  output logic             ovfFlag
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, newestIdx;
  logic             full, doPop, overwrite, doWrite;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full      = (level == LVL_W'(DEPTH));
    empty     = (level == '0);
    doPop     = pop && !empty;
    overwrite = push && full && !doPop;
    doWrite   = push && !overwrite;
    newestIdx = (wrPtr == '0) ? PTR_W'(DEPTH - 1) : wrPtr - 1'b1;
    headData  = mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (overwrite)    mem[newestIdx] <= pushData;
    else if (doWrite) mem[wrPtr]     <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= nextPtr(wrPtr);
      if (doPop)   rdPtr <= nextPtr(rdPtr);
      if (doWrite && !doPop)      level <= level + 1'b1;
      else if (doPop && !doWrite) level <= level - 1'b1;
      if (overwrite)   ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/hybrid_tdc_lane.sv
module hybrid_tdc_lane
  import tdc_lane_pkg::*;
#(
  parameter int TAPS     = 64,
  parameter int COARSE_W = 24,
  parameter int REC_W    = 36,
  parameter int DEPTH    = 512,
  localparam int FINE_W  = $clog2(TAPS + 1),
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulseIn,
  input  logic [TAPS-1:0]   lineA,
  input  logic [TAPS-1:0]   lineB,
  output logic              launchBit,
  output logic              activeSel,
  input  logic              resRd,
  output logic [REC_W-1:0]  resData,
  output logic              resEmpty,
  output logic [LVL_W-1:0]  resLevel,
  input  logic              ovfClr,
  output logic              ovfSticky,
  output logic [FINE_W-1:0] reachA,
  output logic [FINE_W-1:0] reachB
);
  laneStrobe_t       stb;
  logic              recValid;
  logic [REC_W-1:0]  recData;

  tdc_lane_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .pulseIn(pulseIn), .stb(stb), .launchBit(launchBit)
  );

  tdc_lane_dpath #(.TAPS(TAPS), .COARSE_W(COARSE_W), .REC_W(REC_W)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .lineA(lineA), .lineB(lineB),
    .recValid(recValid), .recData(recData), .reachA(reachA), .reachB(reachB)
  );

  tdc_result_fifo #(.DEPTH(DEPTH), .W(REC_W)) uFifo (
    .clk(clk), .rst_n(rst_n), .push(recValid), .pushData(recData),
    .pop(resRd), .headData(resData), .empty(resEmpty), .level(resLevel),
    .ovfClr(ovfClr), .ovfFlag(ovfSticky)
  );

  assign activeSel = stb.phase;
endmodule

// File: rtl/hybrid_tdc_lane_chk.sv
module hybrid_tdc_lane_chk #(
  parameter int TAPS   = 64,
  parameter int DEPTH  = 512,
  localparam int FINE_W = $clog2(TAPS + 1),
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              activeSel,
  input logic              resRd,
  input logic              resEmpty,
  input logic [LVL_W-1:0]  resLevel,
  input logic              ovfSticky,
  input logic [FINE_W-1:0] reachA,
  input logic [FINE_W-1:0] reachB
);
  // R2
  phase_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (activeSel != $past(activeSel)));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resRd && resEmpty && $past(rst_n)) |=> (resLevel <= LVL_W'(1)));

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resLevel == LVL_W'(DEPTH) && !resRd) |=> (resLevel == LVL_W'(DEPTH)));

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovfSticky) && $past(rst_n)) |-> ($past(resLevel) == LVL_W'(DEPTH)));

  // R10
  reach_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (reachA >= $past(reachA) && reachB >= $past(reachB)));

  // R11
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resLevel <= LVL_W'(DEPTH));
endmodule

bind hybrid_tdc_lane hybrid_tdc_lane_chk #(.TAPS(TAPS), .DEPTH(DEPTH)) uChk (
  .clk(clk), .rst_n(rst_n), .activeSel(activeSel), .resRd(resRd),
  .resEmpty(resEmpty), .resLevel(resLevel), .ovfSticky(ovfSticky),
  .reachA(reachA), .reachB(reachB)
);

// File: tb/sim_hybrid_tdc_lane.sv
`timescale 1ns/1ps
module sim_hybrid_tdc_lane;
  localparam int TAPS = 16;
  localparam int CW   = 6;
  localparam int RW   = 36;
  localparam int DEP  = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulseIn = 1'b0;
  logic [TAPS-1:0] lineA = '0, lineB = '0;
  logic launchBit, activeSel, resRd = 1'b0, resEmpty, ovfClr = 1'b0, ovfSticky;
  logic [RW-1:0] resData;
  logic [3:0] resLevel;
  logic [4:0] reachA, reachB;

  int total = 0, bad = 0;
  // model state
  int cntM = 0, phM = 0, leadM = 0, prevP = 0, ovfM = 0;
  logic [RW-1:0] q[$];

  // gap, width, lead, trail
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{2, 1, 3, 7}, '{0, 2, 16, 0}, '{5, 3, 0, 16},
    '{1, 1, 8, 8}, '{10, 4, 12, 1}, '{0, 1, 1, 15}};

  hybrid_tdc_lane #(.TAPS(TAPS), .COARSE_W(CW), .REC_W(RW), .DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .pulseIn(pulseIn), .lineA(lineA), .lineB(lineB),
    .launchBit(launchBit), .activeSel(activeSel), .resRd(resRd), .resData(resData),
    .resEmpty(resEmpty), .resLevel(resLevel), .ovfClr(ovfClr), .ovfSticky(ovfSticky),
    .reachA(reachA), .reachB(reachB));

  always #5 clk = ~clk;

  function automatic logic [TAPS-1:0] therm(input int n);
    return (n >= TAPS) ? '1 : TAPS'((1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input int p, input int nA, input int nB, input int rd, input int clr);
    int fine;
    logic [RW-1:0] rec;
    pulseIn = p[0]; lineA = therm(nA); lineB = therm(nB);
    resRd = rd[0]; ovfClr = clr[0];
    @(posedge clk);
    fine = (phM == 1) ? nA : nB;
    if (rd != 0 && q.size() > 0) void'(q.pop_front());
    if (p != 0 && prevP == 0) leadM = fine;
    if (p == 0 && prevP != 0) begin
      rec = RW'(cntM * TAPS + leadM + fine);
      if (q.size() == DEP && !(rd != 0)) begin q[q.size()-1] = rec; ovfM = 1; end
      else q.push_back(rec);
      cntM = 0;
    end else if (cntM < CMAX) cntM++;
    if (clr != 0 && ovfM == 1 && !(p == 0 && prevP != 0 && q.size() == DEP)) ovfM = 0;
    prevP = p;
    phM = 1 - phM;
    @(negedge clk);
    resRd = 1'b0; ovfClr = 1'b0;
  endtask

  task automatic pulse(input int gap, input int width, input int lead, input int trail);
    for (int i = 0; i < gap; i++) step(0, 0, 0, 0, 0);
    step(1, lead, lead, 0, 0);
    for (int i = 1; i < width; i++) step(1, 0, 0, 0, 0);
    step(0, trail, trail, 0, 0);
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) begin
      chk(resLevel == 4'(q.size()), "R11 level", resLevel, q.size());
      chk(resData == q[0], req, resData, q[0]);
      step(0, 0, 0, 1, 0);
    end
    chk(resEmpty == 1'b1, "R7 empty after drain", resEmpty, 1);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ph0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(resEmpty == 1'b1 && resLevel == 0, "R1 fifo", resLevel, 0);
    chk(ovfSticky == 1'b0, "R1 ovf", ovfSticky, 0);
    chk(reachA == 0 && reachB == 0, "R1 reach", reachA + reachB, 0);
    chk(activeSel == 1'b0, "R1 activeSel", activeSel, 0);
    rst_n = 1'b1;

    // R2 phase alternation and launch value
    ph0 = int'(activeSel);
    step(0, 9, 3, 0, 0);
    chk(int'(activeSel) != ph0, "R2 swap", activeSel, 1 - ph0);
    chk(launchBit == 1'b1, "R2 launch idle", launchBit, 1);
    step(0, 9, 3, 0, 0);
    chk(int'(activeSel) == ph0, "R2 swap back", activeSel, ph0);
    step(0, 2, 2, 0, 0);
    step(0, 2, 2, 0, 0);
    // R10 reach maximum per line (phase 0 samples B, phase 1 samples A)
    chk(reachA == 9, "R10 reachA", reachA, 9);
    chk(reachB == 3, "R10 reachB", reachB, 3);
    chk(resEmpty == 1'b1, "R3 no record without pulse", resEmpty, 1);

    // R7 read on empty ignored
    step(0, 0, 0, 1, 0);
    chk(resLevel == 0 && resEmpty == 1'b1, "R7 empty read", resLevel, 0);

    // R3 R4 R5 table of pulses
    for (int v = 0; v < NV; v++) begin
      pulseIn = 1'b1;
      #1 chk(launchBit == 1'b0, "R2 launch zero", launchBit, 0);
      pulseIn = 1'b0;
      pulse(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      chk(resLevel == 4'(q.size()), "R4 one record per pulse", resLevel, q.size());
    end
    drain("R4 R5 record value");

    // R8 R9 overflow
    for (int i = 0; i < DEP + 2; i++) pulse(0, 1, i, 0);
    chk(resLevel == DEP, "R8 level stays full", resLevel, DEP);
    chk(ovfSticky == 1'b1, "R9 ovf set", ovfSticky, 1);
    chk(resData == q[0], "R8 oldest kept", resData, q[0]);
    chk(q[DEP-1] == RW'(1 * TAPS + DEP + 1), "R8 model newest", q[DEP-1], TAPS + DEP + 1);
    step(0, 0, 0, 0, 1);
    chk(ovfSticky == 1'b0, "R9 ovf cleared", ovfSticky, 0);
    drain("R8 overwrite order");

    // R6 coarse saturation
    for (int i = 0; i < CMAX + 10; i++) step(0, 0, 0, 0, 0);
    pulse(0, 1, 0, 0);
    chk(resData == RW'(CMAX * TAPS + TAPS * 0), "R6 saturated coarse", resData, CMAX * TAPS);
    drain("R6 readout");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule